// File: doc/BRIEF.md
# Mode-Select Arithmetic Logic Unit

This block is a purely combinational W-bit arithmetic logic unit. It has two sections. The arithmetic section is a ripple adder. Its second operand is steered from the B input by a two-bit function code, and a carry input picks the variant. This lets one adder produce transfer, increment, add, add-with-carry, subtract, subtract-with-borrow and decrement. The logic section applies one of four bitwise operations. A single mode input decides which section drives the result.

Each result comes with four status bits: sign, zero, carry and signed overflow. A host data path registers the result and the flags as it needs. The block itself holds no state, has no clock and no reset. Everything settles within the same cycle that the operands are applied.

Top module: `msel_alu`

## Requirements
- R1: `mode_sel` = 0 routes the arithmetic result to `g_out`. `mode_sel` = 1 routes the logic result to `g_out`.
- R2: Arithmetic with `fn_sel` = 2'b00 adds zero to A, so `g_out` = A + `carry_in` (transfer A, or increment A).
- R3: Arithmetic with `fn_sel` = 2'b01 gives `g_out` = A + B + `carry_in` (add, or add with carry).
- R4: Arithmetic with `fn_sel` = 2'b10 gives `g_out` = A + ~B + `carry_in`. This is subtract with borrow when `carry_in` = 0, and A − B when `carry_in` = 1.
- R5: Arithmetic with `fn_sel` = 2'b11 adds all ones, so `g_out` = A − 1 when `carry_in` = 0 and `g_out` = A when `carry_in` = 1.
- R6: Logic mode, keyed by `fn_sel`, gives 2'b00 = A AND B, 2'b01 = A OR B, 2'b10 = A XOR B, 2'b11 = NOT A.
- R7: In arithmetic mode, `carry_out` is the carry out of the most significant bit of the W-bit sum of A, the steered operand and `carry_in`.
- R8: In arithmetic mode, `ovf_flag` is 1 exactly when A and the steered operand share a sign bit and the sign bit of `g_out` differs from it. This is the same as the two's-complement sum, `carry_in` included, falling outside the signed W-bit range.
- R9: `sign_flag` equals the MSB of `g_out`, and `zero_flag` is 1 exactly when `g_out` is all zeros, in both modes.
- R10: In logic mode, `carry_out` and `ovf_flag` are 0, and `carry_in` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | W | First operand |
| b_in | input | W | Second operand, steered in arithmetic mode |
| mode_sel | input | 1 | 0 = arithmetic section, 1 = logic section |
| fn_sel | input | 2 | Function code within the selected section |
| carry_in | input | 1 | Adder carry input, arithmetic mode only |
| g_out | output | W | Result |
| carry_out | output | 1 | Carry out of the MSB |
| sign_flag | output | 1 | MSB of the result |
| zero_flag | output | 1 | Result is all zeros |
| ovf_flag | output | 1 | Two's-complement overflow |

## Verification
Every output of this block is due in the same cycle as its operands, because no register lies on any path. The bench changes the operands one nanosecond after a rising edge and reads all five outputs at the following falling edge. That leaves the ripple chain four nanoseconds of simulated settling time. The bench never reads an output in the delta cycles right after an input change. The expected results come from whole-word integer arithmetic, with signed overflow judged by range, rather than from any per-bit carry logic.

// File: rtl/msel_alu_pkg.sv
package msel_alu_pkg;

  localparam logic [1:0] FN_ZERO = 2'b00;
  localparam logic [1:0] FN_B    = 2'b01;
  localparam logic [1:0] FN_NB   = 2'b10;
  localparam logic [1:0] FN_ONES = 2'b11;

  localparam logic [1:0] LG_AND  = 2'b00;
  localparam logic [1:0] LG_OR   = 2'b01;
  localparam logic [1:0] LG_XOR  = 2'b10;
  localparam logic [1:0] LG_NOTA = 2'b11;

  // one bit of the steered adder operand
  function automatic logic steer_bit(input logic b, input logic [1:0] fn);
    case (fn)
      FN_ZERO: steer_bit = 1'b0;
      FN_B:    steer_bit = b;
      FN_NB:   steer_bit = ~b;
      default: steer_bit = 1'b1;
    endcase
  endfunction

  // full adder: returns {carry, sum}
  function automatic logic [1:0] full_add(input logic x, input logic y, input logic c);
    full_add = {(x & y) | (c & (x ^ y)), x ^ y ^ c};
  endfunction

  // one bit of the logic section
  function automatic logic logic_bit(input logic a, input logic b, input logic [1:0] fn);
    case (fn)
      LG_AND:  logic_bit = a & b;
      LG_OR:   logic_bit = a | b;
      LG_XOR:  logic_bit = a ^ b;
      default: logic_bit = ~a;
    endcase
  endfunction

endpackage

// File: rtl/msel_alu_steer.sv
module msel_alu_steer
  import msel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] b_in,
  input  logic [1:0]   fn_sel,
  output logic [W-1:0] y_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_out[i] = steer_bit(b_in[i], fn_sel);
  end
endmodule

// File: rtl/msel_alu_adder.sv
module msel_alu_adder
  import msel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         c_in,
  output logic [W-1:0] sum_out,
  output logic         c_msb_in,
  output logic         c_out
);
  logic [W:0] chain;
  assign chain[0] = c_in;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic [1:0] fa;
    assign fa         = full_add(x_in[i], y_in[i], chain[i]);
    assign sum_out[i] = fa[0];
    assign chain[i+1] = fa[1];
  end

  assign c_msb_in = chain[W-1];
  assign c_out    = chain[W];
endmodule

// File: rtl/msel_alu_logic.sv
module msel_alu_logic
  import msel_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [1:0]   fn_sel,
  output logic [W-1:0] r_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign r_out[i] = logic_bit(a_in[i], b_in[i], fn_sel);
  end
endmodule

// File: rtl/msel_alu.sv
module msel_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         mode_sel,
  input  logic [1:0]   fn_sel,
  input  logic         carry_in,
  output logic [W-1:0] g_out,
  output logic         carry_out,
  output logic         sign_flag,
  output logic         zero_flag,
  output logic         ovf_flag
);
  localparam int MSB = W - 1;

  // named internal events, observed by the checker
  logic [W-1:0] y_steer;
  logic [W-1:0] sum_raw;
  logic [W-1:0] logic_raw;
  logic         msb_cin;
  logic         add_cout;
  logic         add_ovf;

  msel_alu_steer #(.W(W)) u_steer (
    .b_in   (b_in),
    .fn_sel (fn_sel),
    .y_out  (y_steer)
  );

  msel_alu_adder #(.W(W)) u_adder (
    .x_in     (a_in),
    .y_in     (y_steer),
    .c_in     (carry_in),
    .sum_out  (sum_raw),
    .c_msb_in (msb_cin),
    .c_out    (add_cout)
  );

  msel_alu_logic #(.W(W)) u_logic (
    .a_in   (a_in),
    .b_in   (b_in),
    .fn_sel (fn_sel),
    .r_out  (logic_raw)
  );

  // signed overflow: carry into the MSB disagrees with carry out of it
  assign add_ovf = msb_cin ^ add_cout;

  always_comb begin
    if (mode_sel) begin
      g_out     = logic_raw;
      carry_out = 1'b0;
      ovf_flag  = 1'b0;
    end else begin
      g_out     = sum_raw;
      carry_out = add_cout;
      ovf_flag  = add_ovf;
    end
  end

  assign sign_flag = g_out[MSB];
  assign zero_flag = (g_out == '0);
endmodule

// File: rtl/msel_alu_chk.sv
module msel_alu_chk #(
  parameter int W = 8
) (
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         mode_sel,
  input logic [1:0]   fn_sel,
  input logic         carry_in,
  input logic [W-1:0] g_out,
  input logic         carry_out,
  input logic         sign_flag,
  input logic         zero_flag,
  input logic         ovf_flag,
  input logic [W-1:0] y_steer,
  input logic [W-1:0] sum_raw,
  input logic [W-1:0] logic_raw
);
  logic [W-1:0] inc_ref;
  assign inc_ref = a_in + {{(W-1){1'b0}}, carry_in};

  always_comb begin
    if (mode_sel) AST_MODE_LOGIC: assert (g_out == logic_raw); // R1
    if (!mode_sel) AST_MODE_ARITH: assert (g_out == sum_raw); // R1
    if (!mode_sel && fn_sel == 2'b00) AST_STEER_ZERO: assert (y_steer == '0 && g_out == inc_ref); // R2
    if (!mode_sel && fn_sel == 2'b01) AST_STEER_B: assert (y_steer == b_in); // R3
    if (!mode_sel && fn_sel == 2'b10) AST_STEER_NB: assert ((y_steer ^ b_in) == '1); // R4
    if (!mode_sel && fn_sel == 2'b11) AST_STEER_ONES: assert (&y_steer); // R5
    if (ovf_flag) AST_OVF_SIGNS: assert (!mode_sel && a_in[W-1] == y_steer[W-1] && g_out[W-1] != a_in[W-1]); // R8
    if (mode_sel) AST_LOGIC_NO_CARRY: assert (!carry_out && !ovf_flag); // R10
    if (zero_flag) AST_ZERO_NOT_NEG: assert (!sign_flag && g_out == '0); // R9
  end
endmodule

bind msel_alu msel_alu_chk #(.W(W)) u_chk (
  .a_in      (a_in),
  .b_in      (b_in),
  .mode_sel  (mode_sel),
  .fn_sel    (fn_sel),
  .carry_in  (carry_in),
  .g_out     (g_out),
  .carry_out (carry_out),
  .sign_flag (sign_flag),
  .zero_flag (zero_flag),
  .ovf_flag  (ovf_flag),
  .y_steer   (y_steer),
  .sum_raw   (sum_raw),
  .logic_raw (logic_raw)
);

// File: tb/msel_alu_test.sv
module msel_alu_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         mode_sel = 1'b0;
  logic [1:0]   fn_sel = 2'b00;
  logic         carry_in = 1'b0;
  logic [W-1:0] g_out;
  logic         carry_out, sign_flag, zero_flag, ovf_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  msel_alu #(.W(W)) uut (
    .a_in(a_in), .b_in(b_in), .mode_sel(mode_sel), .fn_sel(fn_sel),
    .carry_in(carry_in), .g_out(g_out), .carry_out(carry_out),
    .sign_flag(sign_flag), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive after a rising edge, sample at the falling edge
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic m, input logic [1:0] f, input logic c);
    @(posedge clk);
    #1;
    a_in = a; b_in = b; mode_sel = m; fn_sel = f; carry_in = c;
    @(negedge clk);
  endtask

  // independent whole-word model; tag names the requirement under test
  task automatic run_vec(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic m, input logic [1:0] f, input logic c);
    logic [W-1:0] y, g;
    logic [W:0]   wide;
    int           ssum;
    logic         ec, eo;
    apply(a, b, m, f, c);
    if (m) begin
      case (f)
        2'b00:   g = a & b;
        2'b01:   g = a | b;
        2'b10:   g = a ^ b;
        default: g = ~a;
      endcase
      ec = 1'b0; eo = 1'b0;
    end else begin
      case (f)
        2'b00:   y = '0;
        2'b01:   y = b;
        2'b10:   y = ~b;
        default: y = '1;
      endcase
      wide = {1'b0, a} + {1'b0, y} + {{W{1'b0}}, c};
      g    = wide[W-1:0];
      ec   = wide[W];
      ssum = int'($signed(a)) + int'($signed(y)) + int'(c);
      eo   = (ssum > (2**(W-1)) - 1) || (ssum < -(2**(W-1)));
    end
    check({tag, " g"},    int'(g_out),     int'(g));
    check({tag, " carry"}, int'(carry_out), int'(ec));
    check({tag, " ovf"},  int'(ovf_flag),  int'(eo));
    check({tag, " sign R9"}, int'(sign_flag), int'(g[W-1]));
    check({tag, " zero R9"}, int'(zero_flag), int'(g == '0));
  endtask

  task automatic t_idle;
    apply('0, '0, 1'b0, 2'b00, 1'b0);
    check("R9 idle g", int'(g_out), 0);
    check("R9 idle zero", int'(zero_flag), 1);
    check("R7 idle carry", int'(carry_out), 0);
  endtask

  task automatic t_transfer_inc;   // R2
    run_vec("R2 transfer", 8'h5A, 8'hFF, 1'b0, 2'b00, 1'b0);
    run_vec("R2 inc", 8'h5A, 8'h00, 1'b0, 2'b00, 1'b1);
    run_vec("R2 inc wrap", 8'hFF, 8'h00, 1'b0, 2'b00, 1'b1);
    run_vec("R2 inc ovf R8", 8'h7F, 8'h33, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_add;            // R3 R7
    run_vec("R3 add", 8'h12, 8'h34, 1'b0, 2'b01, 1'b0);
    run_vec("R3 addc", 8'h12, 8'h34, 1'b0, 2'b01, 1'b1);
    run_vec("R7 add carry", 8'hF0, 8'h20, 1'b0, 2'b01, 1'b0);
    run_vec("R8 add pos ovf", 8'h70, 8'h10, 1'b0, 2'b01, 1'b0);
    run_vec("R8 add neg ovf", 8'h80, 8'h80, 1'b0, 2'b01, 1'b0);
  endtask

  task automatic t_sub;            // R4
    run_vec("R4 sub", 8'h50, 8'h20, 1'b0, 2'b10, 1'b1);
    run_vec("R4 sub borrow", 8'h50, 8'h20, 1'b0, 2'b10, 1'b0);
    run_vec("R4 sub neg", 8'h20, 8'h50, 1'b0, 2'b10, 1'b1);
    run_vec("R4 sub equal", 8'h3C, 8'h3C, 1'b0, 2'b10, 1'b1);
    run_vec("R8 sub ovf", 8'h80, 8'h01, 1'b0, 2'b10, 1'b1);
  endtask

  task automatic t_dec;            // R5
    run_vec("R5 dec", 8'h10, 8'hAA, 1'b0, 2'b11, 1'b0);
    run_vec("R5 dec zero", 8'h00, 8'hAA, 1'b0, 2'b11, 1'b0);
    run_vec("R5 dec ovf", 8'h80, 8'h00, 1'b0, 2'b11, 1'b0);
    run_vec("R5 transfer", 8'hC3, 8'h00, 1'b0, 2'b11, 1'b1);
  endtask

  task automatic t_logic;          // R6 R1
    for (int f = 0; f < 4; f++) begin
      run_vec("R6 logic", 8'hCA, 8'h6C, 1'b1, f[1:0], 1'b0);
      run_vec("R1 logic vs arith", 8'hCA, 8'h6C, 1'b0, f[1:0], 1'b0);
    end
    run_vec("R6 and zero", 8'hF0, 8'h0F, 1'b1, 2'b00, 1'b0);
  endtask

  task automatic t_cin_inert;      // R10
    for (int f = 0; f < 4; f++) begin
      logic [W-1:0] g0;
      apply(8'hFF, 8'hFF, 1'b1, f[1:0], 1'b0);
      g0 = g_out;
      apply(8'hFF, 8'hFF, 1'b1, f[1:0], 1'b1);
      check("R10 cin inert g", int'(g_out), int'(g0));
      check("R10 carry zero", int'(carry_out), 0);
      check("R10 ovf zero", int'(ovf_flag), 0);
    end
  endtask

  task automatic t_sweep;          // R1..R8 mixed
    logic [W-1:0] pats [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'hA5};
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j += 2)
        for (int k = 0; k < 16; k++)
          run_vec("R1 sweep", pats[i], pats[j], k[3], k[1:0], k[2]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle();
    t_transfer_inc();
    t_add();
    t_sub();
    t_dec();
    t_logic();
    t_cin_inert();
    t_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int n = 0; n < 100000; n++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule